// File: doc/BRIEF.md
# Buck Transient Steering Mode Controller

This block is the mode sequencer for a digitally regulated step-down stage that has two extra switches: one in series between the stage and its input rail, and one that returns the inductor to that rail. In regulation it passes the modulator's duty signal to the high-side/low-side pair, with a dead-time gap between them. When the voltage-error sample drops below a programmable trip level, which is what a sudden load drop looks like, it suspends the compensator and modulator. It then reconfigures the switches so that the surplus inductor current flows back into the supply instead of into the output capacitor.

While steering, the block raises the inductor-current converter to its fast sample rate. It subtracts a latched load-step estimate from the remembered steady-state inductor current to get the current at which to stop. It goes back to regulation once a current sample falls to that level, or at once if the error rises above a second limit. The steady-state current is learned only after the error has stayed at zero for a run of switching cycles. A new steering event needs a freshly learned value. All error, threshold and current words are two's-complement.

Top module: `buck_steer_ctrl`

## Requirements
- R1: While `rst` is sampled high, the outputs are: `hs_on`=0, `ls_on`=0, `ser_on`=1, `ret_on`=0, `reg_en`=1, `trans_mode`=0, `fast_rate`=0. The learned steady-state current is marked invalid.
- R2: In regulation, each change of `pwm_in` turns the conducting main switch off on the next cycle. Both main switches then stay off for `dead_clks`+1 cycles before the other one turns on. With `pwm_in`=1 the high side conducts; with `pwm_in`=0 the low side conducts.
- R3: The steady-state current is learned from the first `il_valid` word that follows at least 3 consecutive `sample_tick` cycles with `err`=0, with no non-zero sample in between. Until it has been learned, no error value starts a steering event.
- R4: In regulation, with a learned current, a `sample_tick` with `err` < `trans_th` (signed, strict) starts a steering event. On the next cycle all four switches are off, `reg_en`=0 and `fast_rate`=1, and `trans_mode` is high for exactly that one cycle. `err` equal to `trans_th` does not trip.
- R5: After `dead_clks`+1 all-off cycles, `ls_on` and `ret_on` turn on together. `fast_rate` stays 1 throughout the steering event.
- R6: The stop current is the learned current minus `step_code`, where `step_code` is sampled in the `trans_mode` cycle. The result saturates at 0 when negative and at the largest positive word when it overflows. The event ends on an `il_valid` sample with `il_code` ≤ stop current (signed). A larger sample leaves steering unchanged.
- R7: Leaving steering turns `ret_on` and `fast_rate` off on the next cycle, with `ls_on` still on and `ser_on` still off. After `dead_clks`+1 such cycles, `ser_on` and `reg_en` return to 1.
- R8: During a steering event, a `sample_tick` with `err` > `max_th` (signed, strict) leaves steering through the R7 sequence, whatever the current. `err` equal to `max_th` does not abort.
- R9: Every steering event discards the learned current. A second event is refused until R3 has learned a new value.
- R10: `ser_on` and `ret_on` are never both 1, and `hs_on` and `ls_on` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle strobe per switching cycle; `err` valid |
| err | input | EW | Signed voltage-error sample |
| trans_th | input | EW | Signed load-drop trip level |
| max_th | input | EW | Signed abort limit during steering |
| dead_clks | input | DW | Gap length minus one, in clocks |
| pwm_in | input | 1 | Duty signal from the modulator |
| il_valid | input | 1 | Strobe: `il_code` holds a new sample |
| il_code | input | IW | Signed inductor-current sample |
| step_code | input | IW | Signed load-step estimate from the flash converter |
| hs_on | output | 1 | High-side main switch enable |
| ls_on | output | 1 | Low-side main switch enable |
| ser_on | output | 1 | Series steering switch enable |
| ret_on | output | 1 | Return steering switch enable |
| reg_en | output | 1 | Compensator and modulator enable |
| trans_mode | output | 1 | One-cycle pulse that latches the load-step estimate |
| fast_rate | output | 1 | Selects the fast current-sampling rate |

## Verification
The hardest state to reach is a steering event that ends on a current sample exactly at a saturated stop level. That needs a learned current smaller than the load-step estimate, so the stimulus first drives a run of zero-error ticks and a small current word, then trips the detector and offers samples just above and at zero. Strict boundaries on both thresholds are driven at the equal value. Another case drives an interrupted zero run. Re-arming is probed by tripping the detector straight after an event ends.

// File: rtl/buck_steer_ctrl.sv
module buck_steer_ctrl #(
  parameter int EW = 8,
  parameter int IW = 10,
  parameter int DW = 4,
  parameter int ZERO_RUN = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_tick,
  input  logic signed [EW-1:0] err,
  input  logic signed [EW-1:0] trans_th,
  input  logic signed [EW-1:0] max_th,
  input  logic [DW-1:0]        dead_clks,
  input  logic                 pwm_in,
  input  logic                 il_valid,
  input  logic signed [IW-1:0] il_code,
  input  logic signed [IW-1:0] step_code,
  output logic                 hs_on,
  output logic                 ls_on,
  output logic                 ser_on,
  output logic                 ret_on,
  output logic                 reg_en,
  output logic                 trans_mode,
  output logic                 fast_rate
);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam int TGT_MAX = (1 << (IW - 1)) - 1;

  typedef enum logic [1:0] {S_NORM, S_ENTER, S_STEER, S_LEAVE} st_t;

  st_t                  st;
  logic [DW-1:0]        gap_cnt, dt_cnt;
  logic                 hs_r, ls_r, trans_r, old_vld;
  logic [ZW-1:0]        zc;
  logic signed [IW-1:0] il_old, il_tgt;
  logic signed [IW:0]   diff;
  logic                 detect, abort, reach, gap_done;

  assign detect   = sample_tick && old_vld && (err < trans_th);
  assign abort    = sample_tick && (err > max_th);
  assign reach    = il_valid && (il_code <= il_tgt);
  assign gap_done = (gap_cnt == '0);
  assign diff     = il_old - step_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_NORM;
      gap_cnt <= '0;
      trans_r <= 1'b0;
    end else begin
      trans_r <= 1'b0;
      case (st)
        S_NORM: if (detect) begin
          st      <= S_ENTER;
          gap_cnt <= dead_clks;
          trans_r <= 1'b1;
        end
        S_ENTER: if (abort) begin
          st      <= S_LEAVE;
          gap_cnt <= dead_clks;
        end else if (gap_done) st <= S_STEER;
        else gap_cnt <= gap_cnt - 1'b1;
        S_STEER: if (abort || reach) begin
          st      <= S_LEAVE;
          gap_cnt <= dead_clks;
        end
        default: if (gap_done) st <= S_NORM;
        else gap_cnt <= gap_cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) il_tgt <= '0;
    else if (trans_r) begin
      if (diff < 0) il_tgt <= '0;
      else if (diff > TGT_MAX) il_tgt <= IW'(TGT_MAX);
      else il_tgt <= diff[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zc      <= '0;
      old_vld <= 1'b0;
      il_old  <= '0;
    end else if (st != S_NORM) begin
      zc      <= '0;
      old_vld <= 1'b0;
    end else begin
      if (sample_tick)
        zc <= (err != 0) ? '0 : (zc == ZW'(ZERO_RUN)) ? zc : zc + 1'b1;
      if (il_valid && !old_vld && zc == ZW'(ZERO_RUN)) begin
        il_old  <= il_code;
        old_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_r   <= 1'b0;
      ls_r   <= 1'b0;
      dt_cnt <= '0;
    end else if (st != S_NORM) begin
      hs_r   <= 1'b0;
      ls_r   <= 1'b1;
      dt_cnt <= '0;
    end else if (pwm_in ? hs_r : ls_r) begin
      dt_cnt <= '0;
    end else if (hs_r || ls_r) begin
      hs_r   <= 1'b0;
      ls_r   <= 1'b0;
      dt_cnt <= dead_clks;
    end else if (dt_cnt == '0) begin
      hs_r <= pwm_in;
      ls_r <= !pwm_in;
    end else begin
      dt_cnt <= dt_cnt - 1'b1;
    end
  end

  assign hs_on      = (st == S_NORM) && hs_r;
  assign ls_on      = (st == S_NORM) ? ls_r : (st == S_STEER || st == S_LEAVE);
  assign ser_on     = (st == S_NORM);
  assign ret_on     = (st == S_STEER);
  assign reg_en     = (st == S_NORM);
  assign fast_rate  = (st == S_ENTER || st == S_STEER);
  assign trans_mode = trans_r;

  AST_SWAP_EXCL: assert property (@(posedge clk) disable iff (rst) !(ser_on && ret_on)); // R10
  AST_MAIN_EXCL: assert property (@(posedge clk) disable iff (rst) !(hs_on && ls_on)); // R10
  AST_RET_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) $rose(ret_on) |-> $past(!ser_on && !ls_on)); // R5
  AST_SER_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) $rose(ser_on) |-> $past(!ret_on)); // R7
  AST_TRANS_ONE: assert property (@(posedge clk) disable iff (rst) trans_mode |=> !trans_mode); // R4
  AST_ENTRY_STROBE: assert property (@(posedge clk) disable iff (rst) $fell(reg_en) |-> trans_mode); // R4
  AST_TGT_NONNEG: assert property (@(posedge clk) disable iff (rst) !il_tgt[IW-1]); // R6
  AST_ENTRY_ARMED: assert property (@(posedge clk) disable iff (rst) trans_mode |-> $past(old_vld)); // R9
endmodule

// File: tb/buck_steer_ctrl_tb.sv
module buck_steer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 8;
  localparam int IW = 10;
  localparam int DW = 4;

  localparam logic [6:0] M_ALL  = 7'b1111111;
  localparam logic [6:0] M_HSLS = 7'b1100000;
  localparam logic [6:0] M_SER  = 7'b0010000;
  localparam logic [6:0] M_RET  = 7'b0001000;
  localparam logic [6:0] M_REG  = 7'b0000100;
  localparam logic [6:0] M_TRN  = 7'b0000010;
  localparam logic [6:0] M_FST  = 7'b0000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_tick = 1'b0;
  logic signed [EW-1:0] err = '0;
  logic signed [EW-1:0] trans_th = -8'sd20;
  logic signed [EW-1:0] max_th = 8'sd30;
  logic [DW-1:0] dead_clks = 4'd2;
  logic pwm_in = 1'b0;
  logic il_valid = 1'b0;
  logic signed [IW-1:0] il_code = '0;
  logic signed [IW-1:0] step_code = '0;
  logic hs_on, ls_on, ser_on, ret_on, reg_en, trans_mode, fast_rate;
  logic [6:0] obs;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int overlap = 0;

  typedef struct {
    int         cyc;
    logic [6:0] m;
    logic [6:0] v;
    string      r;
  } item_t;
  item_t q[$];

  buck_steer_ctrl #(.EW(EW), .IW(IW), .DW(DW), .ZERO_RUN(3)) u_dut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .err(err),
    .trans_th(trans_th), .max_th(max_th), .dead_clks(dead_clks),
    .pwm_in(pwm_in), .il_valid(il_valid), .il_code(il_code),
    .step_code(step_code), .hs_on(hs_on), .ls_on(ls_on), .ser_on(ser_on),
    .ret_on(ret_on), .reg_en(reg_en), .trans_mode(trans_mode),
    .fast_rate(fast_rate)
  );

  assign obs = {hs_on, ls_on, ser_on, ret_on, reg_en, trans_mode, fast_rate};

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    item_t it;
    if (!rst && ((hs_on && ls_on) || (ser_on && ret_on))) overlap++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      n_chk++;
      if ((((obs ^ it.v) & it.m) != 0) || it.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s: got %b exp %b mask %b at cycle %0d (due %0d)",
                 it.r, obs, it.v, it.m, cyc, it.cyc);
      end
    end
  end

  task automatic tk();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  task automatic expect_at(int dc, logic [6:0] m, logic [6:0] v, string r);
    q.push_back('{cyc + dc, m, v, r});
  endtask

  task automatic tick_err(int e);
    sample_tick = 1'b1;
    err = EW'(e);
    tk();
    sample_tick = 1'b0;
    err = '0;
  endtask

  task automatic learn(int v);
    tick_err(0);
    tick_err(0);
    tick_err(0);
    il_valid = 1'b1;
    il_code = IW'(v);
    tk();
    il_valid = 1'b0;
    run(2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    run(3);
    expect_at(0, M_ALL, 7'b0010100, "R1 reset outputs");
    rst = 1'b0;
    expect_at(1, M_ALL, 7'b0110100, "R2 low side after reset");
    run(3);

    // R2 dead-time on both edges
    pwm_in = 1'b1;
    expect_at(1, M_HSLS, 7'b0000000, "R2 low side off");
    expect_at(3, M_HSLS, 7'b0000000, "R2 gap held");
    expect_at(4, M_HSLS, 7'b1000000, "R2 high side on");
    run(6);
    pwm_in = 1'b0;
    expect_at(1, M_HSLS, 7'b0000000, "R2 high side off");
    expect_at(3, M_HSLS, 7'b0000000, "R2 gap held");
    expect_at(4, M_HSLS, 7'b0100000, "R2 low side on");
    run(6);

    // R3 interrupted zero run learns nothing
    tick_err(0);
    tick_err(0);
    tick_err(3);
    il_valid = 1'b1;
    il_code = 10'sd200;
    tk();
    il_valid = 1'b0;
    expect_at(1, M_REG | M_TRN, 7'b0000100, "R3 no trip without learned current");
    tick_err(-50);
    run(3);

    // Event 1: learned 200, step 120, stop at 80
    step_code = 10'sd120;
    learn(200);
    expect_at(1, M_REG | M_TRN, 7'b0000100, "R4 equal to trip level");
    tick_err(-20);
    run(2);
    expect_at(1, M_ALL, 7'b0000011, "R4 entry all off");
    expect_at(2, M_ALL, 7'b0000001, "R4 strobe one cycle");
    expect_at(3, M_ALL, 7'b0000001, "R5 gap held");
    expect_at(4, M_ALL, 7'b0101001, "R5 steering on");
    tick_err(-50);
    run(3);
    il_valid = 1'b1;
    il_code = 10'sd100;
    expect_at(1, M_ALL, 7'b0101001, "R6 above stop keeps steering");
    tk();
    il_code = 10'sd80;
    expect_at(1, M_ALL, 7'b0100000, "R7 leave gap");
    expect_at(3, M_ALL, 7'b0100000, "R7 leave gap held");
    expect_at(4, M_ALL, 7'b0110100, "R7 regulation back");
    tk();
    il_valid = 1'b0;
    run(5);

    expect_at(1, M_REG | M_TRN, 7'b0000100, "R9 no retrigger before relearn");
    tick_err(-50);
    run(2);

    // Event 2: learned 50, step 120, stop saturates to 0
    learn(50);
    expect_at(1, M_TRN, 7'b0000010, "R4 trip");
    tick_err(-50);
    run(3);
    il_valid = 1'b1;
    il_code = 10'sd5;
    expect_at(1, M_RET, 7'b0001000, "R6 saturated stop not reached");
    tk();
    il_code = 10'sd0;
    expect_at(1, M_RET | M_FST, 7'b0000000, "R6 saturated stop reached");
    tk();
    il_valid = 1'b0;
    run(6);

    // Event 3: abort on error limit
    step_code = 10'sd20;
    learn(200);
    tick_err(-50);
    run(3);
    expect_at(1, M_RET, 7'b0001000, "R8 equal to limit keeps steering");
    tick_err(30);
    expect_at(1, M_RET | M_FST | M_SER, 7'b0000000, "R8 abort leaves steering");
    expect_at(4, M_SER | M_REG, 7'b0010100, "R8 regulation after abort");
    tick_err(31);
    run(6);

    n_chk++;
    if (overlap != 0) begin
      n_fail++;
      $display("FAIL R10 overlap: got %0d exp 0", overlap);
    end
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL pending: got %0d exp 0", q.size());
    end
    finish_run();
  end
endmodule